// File: doc/BRIEF.md
# Audio-Level Supply Rail Selector

This block watches a stream of signed digital audio samples and decides which of two supply rails should power a Class-D output bridge: the high rail for loud passages, the low rail for quiet ones. For each valid sample it takes the magnitude and compares it with an active threshold. A sample at or above the threshold selects the high rail on that same sample. The low rail is chosen only after a run of quiet samples longer than a programmable hold time.

The threshold has three sources. It can be an offset below a digital word that reports the low-rail level, or a fixed code on a dBFS-like scale. A dedicated supply-mode value overrides both with a coarse 2-bit code. The hold time is a 4-bit code scaled to a number of valid samples. The outputs are the rail-select flag and a one-cycle pulse on every rail change. The analog switching, the measurement of the rail voltage and the sample source are outside the block.

Top module: `rail_picker`

## Requirements
- R1: The decision uses the sample magnitude, so a negative sample acts like its positive counterpart, and the most negative code -2^(SAMPLE_W-1) has magnitude 2^(SAMPLE_W-1), which is at least any threshold.
- R2: A valid sample whose magnitude is greater than or equal to the active threshold leaves or puts the block on the high rail (`rail_hi` = 1); equality counts as loud.
- R3: With the hold limit L = (hyst_code + 1) * HOLD_STEP, the block moves to the low rail on the valid quiet sample that follows L consecutive valid quiet samples, and not earlier.
- R4: A loud valid sample received on the low rail returns `rail_hi` to 1 in the cycle after that sample, and any loud sample restarts the quiet run from zero.
- R5: With `thr_rel_sel` = 1 and `pwr_mode` not 2'b11, the threshold is low_level - rel_code * MARGIN_STEP, floored at zero.
- R6: With `thr_rel_sel` = 0 and `pwr_mode` not 2'b11, and FS = 2^(SAMPLE_W-1), the threshold is B = FS >> fix_code[4:1], reduced by B >> 2 when fix_code[0] is 1 (about 3 dB per code step).
- R7: With `pwr_mode` = 2'b11, the threshold is FS >> (LOW_SHIFT + low_code), whatever the value of `thr_rel_sel`.
- R8: During and right after reset, `rail_hi` is 1, `rail_chg` is 0 and the quiet run is zero.
- R9: `rail_chg` is 1 for exactly one cycle after each rail change and 0 in every other cycle.
- R10: The quiet-run counter saturates instead of wrapping; if the hold code is lowered below the run already counted, the next quiet sample releases to the low rail.
- R11: Cycles with `smp_valid` = 0 change neither the rail nor the quiet run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | SAMPLE_W | Signed two's-complement audio sample |
| low_level | input | SAMPLE_W | Low-rail level on the sample magnitude scale |
| thr_rel_sel | input | 1 | 1: threshold relative to low_level, 0: fixed code |
| rel_code | input | 4 | Margin steps below low_level |
| fix_code | input | 5 | Fixed threshold code |
| pwr_mode | input | 2 | Supply mode; 2'b11 selects the coarse override |
| low_code | input | 2 | Coarse threshold code used in the override mode |
| hyst_code | input | 4 | Hold time code |
| rail_hi | output | 1 | 1: high rail selected, 0: low rail |
| rail_chg | output | 1 | One-cycle pulse on each rail change |

## Verification
The release of the hold timer and a configuration change can land on the same sample. When the hold code is lowered while a quiet run is under way, or the threshold source is switched just as a borderline sample arrives, the decision for that sample must use the new settings. The bench provokes both: it shortens the hold code after a long quiet run and changes the threshold mode between samples of equal magnitude. A behavioural model evaluates each sample against the settings of its own cycle, and the outputs are compared with the model on every clock.

// File: rtl/rail_pkg.sv
// Shared widths and code values for the supply rail selector.
package rail_pkg;
    localparam int REL_W  = 4;   // relative margin code width
    localparam int FIX_W  = 5;   // fixed threshold code width
    localparam int PWR_W  = 2;   // supply mode width
    localparam int LOWC_W = 2;   // coarse override code width
    localparam int HYST_W = 4;   // hold code width
    localparam logic [PWR_W-1:0] PWR_OVERRIDE = 2'b11;
endpackage

// File: rtl/mag_abs.sv
// Magnitude of a signed sample.
// Assumes two's complement; the result is one bit wider in range than
// the positive half, so the most negative code maps to 2^(W-1) unchanged.
module mag_abs #(
    parameter int W = 16
) (
    input  logic [W-1:0] data_i,
    output logic [W-1:0] mag_o
);
    // Negate negative samples, pass positive ones.
    always_comb begin
        if (data_i[W-1]) mag_o = (~data_i) + W'(1);
        else             mag_o = data_i;
    end
endmodule

// File: rtl/thr_select.sv
// Active threshold computation.
// Chooses among a margin below the low-rail level word, a fixed code with
// roughly 3 dB steps, and a coarse override used in one supply mode.
// Assumes all codes are static or change only between samples.
module thr_select
    import rail_pkg::*;
#(
    parameter int W           = 16,
    parameter int MARGIN_STEP = 256,
    parameter int LOW_SHIFT   = 4
) (
    input  logic [W-1:0]      low_level_i,
    input  logic              rel_sel_i,
    input  logic [REL_W-1:0]  rel_code_i,
    input  logic [FIX_W-1:0]  fix_code_i,
    input  logic [PWR_W-1:0]  pwr_mode_i,
    input  logic [LOWC_W-1:0] low_code_i,
    output logic [W-1:0]      thr_o
);
    localparam int MW = W + REL_W + 1;
    localparam logic [W-1:0] FS = W'(1) << (W - 1);

    logic [MW-1:0] margin;
    logic [MW-1:0] level_ext;
    logic [W-1:0]  rel_thr;
    logic [W-1:0]  fix_base;
    logic [W-1:0]  fix_thr;
    logic [W-1:0]  ovr_thr;

    // Relative threshold: level minus scaled margin, clamped at zero.
    always_comb begin
        margin    = MW'(rel_code_i) * MW'(MARGIN_STEP);
        level_ext = MW'(low_level_i);
        if (margin >= level_ext) rel_thr = '0;
        else                     rel_thr = W'(level_ext - margin);
    end

    // Fixed threshold: 6 dB per pair of codes, odd codes drop a quarter more.
    always_comb begin
        fix_base = FS >> fix_code_i[FIX_W-1:1];
        fix_thr  = fix_code_i[0] ? (fix_base - (fix_base >> 2)) : fix_base;
    end

    // Coarse override threshold for the special supply mode.
    always_comb begin
        ovr_thr = FS >> (LOW_SHIFT + int'(low_code_i));
    end

    // Source priority: override mode first, then the mode bit.
    always_comb begin
        if (pwr_mode_i == PWR_OVERRIDE) thr_o = ovr_thr;
        else if (rel_sel_i)             thr_o = rel_thr;
        else                            thr_o = fix_thr;
    end
endmodule

// File: rtl/hold_timer.sv
// Rail decision state with a quiet-run hold timer.
// Moves to the low rail after more than (hyst+1)*HOLD_STEP consecutive
// quiet samples; returns to the high rail on the first loud sample.
// Assumes quiet_i is meaningful only when valid_i is high.
module hold_timer
    import rail_pkg::*;
#(
    parameter int HOLD_STEP = 4,
    parameter int CNT_W     = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic              quiet_i,
    input  logic [HYST_W-1:0] hyst_i,
    output logic              rail_hi_o,
    output logic              rail_chg_o,
    output logic [CNT_W-1:0]  cnt_o
);
    logic [CNT_W-1:0] limit;

    // Hold limit in valid samples for the current code.
    always_comb begin
        limit = CNT_W'((int'(hyst_i) + 1) * HOLD_STEP);
    end

    // Rail state, change pulse and saturating quiet-run counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rail_hi_o  <= 1'b1;
            rail_chg_o <= 1'b0;
            cnt_o      <= '0;
        end else begin
            rail_chg_o <= 1'b0;
            if (valid_i) begin
                if (!quiet_i) begin
                    cnt_o <= '0;
                    if (!rail_hi_o) begin
                        rail_hi_o  <= 1'b1;
                        rail_chg_o <= 1'b1;
                    end
                end else if (rail_hi_o) begin
                    if (cnt_o >= limit) begin
                        rail_hi_o  <= 1'b0;
                        rail_chg_o <= 1'b1;
                    end else begin
                        cnt_o <= cnt_o + CNT_W'(1);
                    end
                end
            end
        end
    end
endmodule

// File: rtl/rail_picker.sv
// Audio-level supply rail selector, top level.
// Compares each valid sample magnitude with the active threshold and
// drives the rail-select flag through the hold timer.
// Assumes synchronous active-low reset and configuration stable per sample.
module rail_picker
    import rail_pkg::*;
#(
    parameter int SAMPLE_W    = 16,
    parameter int MARGIN_STEP = 256,
    parameter int LOW_SHIFT   = 4,
    parameter int HOLD_STEP   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic [SAMPLE_W-1:0] low_level,
    input  logic                thr_rel_sel,
    input  logic [REL_W-1:0]    rel_code,
    input  logic [FIX_W-1:0]    fix_code,
    input  logic [PWR_W-1:0]    pwr_mode,
    input  logic [LOWC_W-1:0]   low_code,
    input  logic [HYST_W-1:0]   hyst_code,
    output logic                rail_hi,
    output logic                rail_chg
);
    localparam int MAX_HOLD = (1 << HYST_W) * HOLD_STEP;
    localparam int CNT_W    = $clog2(MAX_HOLD + 1);

    logic [SAMPLE_W-1:0] mag_w;
    logic [SAMPLE_W-1:0] thr_w;
    logic                quiet_w;
    logic [CNT_W-1:0]    cnt_w;

    mag_abs #(.W(SAMPLE_W)) u_mag (
        .data_i (smp_data),
        .mag_o  (mag_w)
    );

    thr_select #(
        .W           (SAMPLE_W),
        .MARGIN_STEP (MARGIN_STEP),
        .LOW_SHIFT   (LOW_SHIFT)
    ) u_thr (
        .low_level_i (low_level),
        .rel_sel_i   (thr_rel_sel),
        .rel_code_i  (rel_code),
        .fix_code_i  (fix_code),
        .pwr_mode_i  (pwr_mode),
        .low_code_i  (low_code),
        .thr_o       (thr_w)
    );

    // Quiet means strictly below the active threshold.
    always_comb begin
        quiet_w = (mag_w < thr_w);
    end

    hold_timer #(
        .HOLD_STEP (HOLD_STEP),
        .CNT_W     (CNT_W)
    ) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_i    (smp_valid),
        .quiet_i    (quiet_w),
        .hyst_i     (hyst_code),
        .rail_hi_o  (rail_hi),
        .rail_chg_o (rail_chg),
        .cnt_o      (cnt_w)
    );
endmodule

// File: rtl/rail_picker_chk.sv
// Assertion checker for the rail selector, bound to every instance.
module rail_picker_chk #(
    parameter int SAMPLE_W = 16,
    parameter int CNT_W    = 7
) (
    input logic                clk,
    input logic                rst_n,
    input logic                smp_valid,
    input logic [SAMPLE_W-1:0] mag,
    input logic [SAMPLE_W-1:0] thr,
    input logic [CNT_W-1:0]    cnt,
    input logic                rail_hi,
    input logic                rail_chg
);
    // Reset leaves the high rail selected and no pulse.
    assert_reset_state_R8: assert property (@(posedge clk)
        !rst_n |=> (rail_hi && !rail_chg && cnt == '0));

    // A pulse accompanies exactly the cycles where the rail flips.
    assert_chg_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rail_chg == (rail_hi != $past(rail_hi)));

    // A loud sample always ends on the high rail.
    assert_loud_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && mag >= thr) |=> rail_hi);

    // A loud sample restarts the quiet run.
    assert_loud_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && mag >= thr) |=> (cnt == '0));

    // Entering the low rail needs a quiet valid sample.
    assert_low_needs_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rail_hi) |-> $past(smp_valid && mag < thr));

    // Idle cycles leave rail and counter untouched.
    assert_idle_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> ($stable(rail_hi) && $stable(cnt) && !rail_chg));

    // The quiet counter never wraps while counting on the high rail.
    assert_no_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && mag < thr && rail_hi) |=> (cnt >= $past(cnt)));
endmodule

bind rail_picker rail_picker_chk #(
    .SAMPLE_W (SAMPLE_W),
    .CNT_W    (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .mag       (mag_w),
    .thr       (thr_w),
    .cnt       (cnt_w),
    .rail_hi   (rail_hi),
    .rail_chg  (rail_chg)
);

// File: tb/tb_rail_picker.sv
// Bench for the rail selector: behavioural model compared on every clock,
// plus directed checks on the corner cases.
`timescale 1ns/1ps
module tb_rail_picker;
    localparam int SW   = 16;
    localparam int MSTEP = 256;
    localparam int LSH  = 4;
    localparam int HSTEP = 4;
    localparam int FSV  = 32768;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_valid = 1'b0;
    logic [SW-1:0] smp_data = '0;
    logic [SW-1:0] low_level = 16'd8192;
    logic          thr_rel_sel = 1'b1;
    logic [3:0]    rel_code = 4'd2;
    logic [4:0]    fix_code = 5'd3;
    logic [1:0]    pwr_mode = 2'd0;
    logic [1:0]    low_code = 2'd1;
    logic [3:0]    hyst_code = 4'd0;
    logic          rail_hi;
    logic          rail_chg;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 0;
    bit started = 0;
    string cur_req = "R8";

    // Reference model state.
    int m_hi = 1;
    int m_chg = 0;
    int m_cnt = 0;

    always #2.5 clk = ~clk;

    rail_picker #(
        .SAMPLE_W (SW), .MARGIN_STEP (MSTEP), .LOW_SHIFT (LSH), .HOLD_STEP (HSTEP)
    ) dut (
        .clk (clk), .rst_n (rst_n), .smp_valid (smp_valid), .smp_data (smp_data),
        .low_level (low_level), .thr_rel_sel (thr_rel_sel), .rel_code (rel_code),
        .fix_code (fix_code), .pwr_mode (pwr_mode), .low_code (low_code),
        .hyst_code (hyst_code), .rail_hi (rail_hi), .rail_chg (rail_chg)
    );

    function automatic int ref_thr();
        int base;
        if (pwr_mode == 2'b11) return FSV >> (LSH + int'(low_code));
        if (thr_rel_sel) begin
            base = int'(low_level) - int'(rel_code) * MSTEP;
            return (base < 0) ? 0 : base;
        end
        base = FSV >> int'(fix_code[4:1]);
        return fix_code[0] ? base - (base / 4) : base;
    endfunction

    function automatic int ref_mag();
        int s;
        s = int'($signed(smp_data));
        return (s < 0) ? -s : s;
    endfunction

    // Behavioural model of the rail decision, updated at each rising edge.
    always @(posedge clk) begin
        started <= 1;
        if (!rst_n) begin
            m_hi <= 1; m_chg <= 0; m_cnt <= 0;
        end else begin
            m_chg <= 0;
            if (smp_valid) begin
                if (ref_mag() >= ref_thr()) begin
                    m_cnt <= 0;
                    if (m_hi == 0) begin m_hi <= 1; m_chg <= 1; end
                end else if (m_hi == 1) begin
                    if (m_cnt >= (int'(hyst_code) + 1) * HSTEP) begin
                        m_hi <= 0; m_chg <= 1;
                    end else begin
                        m_cnt <= m_cnt + 1;
                    end
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Compare outputs with the model away from the rising edge.
    always @(negedge clk) begin
        if (started && !done) begin
            chk(int'(rail_hi) == m_hi, {cur_req, " model rail_hi"}, int'(rail_hi), m_hi);
            chk(int'(rail_chg) == m_chg, {"R9 model rail_chg in ", cur_req}, int'(rail_chg), m_chg);
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    // Watchdog: a hung run is a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            finish_run();
        end
    end

    // Present one valid sample; return once its result is visible.
    task automatic send(input int d);
        smp_valid = 1'b1;
        smp_data = SW'(d);
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        idle(4);
        cur_req = "R8";
        chk(rail_hi == 1'b1, "R8 rail_hi in reset", int'(rail_hi), 1);
        chk(rail_chg == 1'b0, "R8 rail_chg in reset", int'(rail_chg), 0);
        rst_n = 1'b1;
        idle(1);
        chk(rail_hi == 1'b1, "R8 rail_hi after reset", int'(rail_hi), 1);

        // Relative threshold 8192 - 2*256 = 7680; equality is loud.
        cur_req = "R2";
        send(7680);
        chk(rail_hi == 1'b1, "R2 equal magnitude", int'(rail_hi), 1);
        send(-7680);
        chk(rail_hi == 1'b1, "R1 negative equal magnitude", int'(rail_hi), 1);

        // Hold limit 4: fifth quiet sample releases.
        cur_req = "R3";
        for (int i = 0; i < 4; i++) send(7679);
        chk(rail_hi == 1'b1, "R3 still high after limit", int'(rail_hi), 1);
        send(7679);
        chk(rail_hi == 1'b0, "R3 low after limit+1", int'(rail_hi), 0);
        chk(rail_chg == 1'b1, "R9 pulse on release", int'(rail_chg), 1);
        idle(1);
        chk(rail_chg == 1'b0, "R9 pulse one cycle", int'(rail_chg), 0);

        cur_req = "R4";
        send(-7680);
        chk(rail_hi == 1'b1, "R4 immediate return", int'(rail_hi), 1);
        chk(rail_chg == 1'b1, "R9 pulse on return", int'(rail_chg), 1);

        // Idle cycles do not extend the quiet run.
        cur_req = "R11";
        for (int i = 0; i < 4; i++) send(0);
        idle(10);
        chk(rail_hi == 1'b1, "R11 idle not counted", int'(rail_hi), 1);
        cur_req = "R4";
        send(7680);
        for (int i = 0; i < 4; i++) send(0);
        chk(rail_hi == 1'b1, "R4 loud sample restarts run", int'(rail_hi), 1);
        send(0);
        chk(rail_hi == 1'b0, "R4 release after restart", int'(rail_hi), 0);

        // Fixed code 3: 16384 - 4096 = 12288.
        cur_req = "R6";
        thr_rel_sel = 1'b0;
        send(12287);
        chk(rail_hi == 1'b0, "R6 below fixed threshold", int'(rail_hi), 0);
        send(12288);
        chk(rail_hi == 1'b1, "R6 at fixed threshold", int'(rail_hi), 1);

        // Override: 32768 >> 5 = 1024, even with the relative mode bit set.
        cur_req = "R7";
        thr_rel_sel = 1'b1;
        pwr_mode = 2'b11;
        for (int i = 0; i < 5; i++) send(1023);
        chk(rail_hi == 1'b0, "R7 release under override", int'(rail_hi), 0);
        send(1024);
        chk(rail_hi == 1'b1, "R7 override beats relative", int'(rail_hi), 1);

        // Fixed code 0: threshold FS; only the most negative code reaches it.
        cur_req = "R1";
        pwr_mode = 2'b00;
        thr_rel_sel = 1'b0;
        fix_code = 5'd0;
        for (int i = 0; i < 5; i++) send(32767);
        chk(rail_hi == 1'b0, "R1 max positive is quiet", int'(rail_hi), 0);
        send(-32768);
        chk(rail_hi == 1'b1, "R1 most negative is loud", int'(rail_hi), 1);

        // Lowering the hold code below the elapsed run releases at once.
        cur_req = "R10";
        thr_rel_sel = 1'b1;
        hyst_code = 4'd15;
        for (int i = 0; i < 30; i++) send(0);
        chk(rail_hi == 1'b1, "R10 long hold not expired", int'(rail_hi), 1);
        hyst_code = 4'd0;
        send(0);
        chk(rail_hi == 1'b0, "R10 shortened hold releases", int'(rail_hi), 0);

        // Relative floor at zero: every sample is loud.
        cur_req = "R5";
        low_level = 16'd1000;
        rel_code = 4'd15;
        send(0);
        chk(rail_hi == 1'b1, "R5 zero threshold loud", int'(rail_hi), 1);
        for (int i = 0; i < 10; i++) send(0);
        chk(rail_hi == 1'b1, "R5 floor keeps high", int'(rail_hi), 1);
        rel_code = 4'd1;
        for (int i = 0; i < 5; i++) send(743);
        chk(rail_hi == 1'b0, "R5 margin threshold 744", int'(rail_hi), 0);
        send(-744);
        chk(rail_hi == 1'b1, "R5 at margin threshold", int'(rail_hi), 1);

        // Mixed traffic and settings, judged by the model.
        cur_req = "R3 mixed";
        for (int i = 0; i < 4000; i++) begin
            if (i % 97 == 0) begin
                thr_rel_sel = 1'($urandom);
                rel_code = 4'($urandom);
                fix_code = 5'($urandom_range(0, 8));
                pwr_mode = 2'($urandom);
                low_code = 2'($urandom);
                hyst_code = 4'($urandom_range(0, 3));
                low_level = 16'($urandom_range(0, 16000));
            end
            smp_valid = ($urandom % 4) != 0;
            if ($urandom % 8 == 0) smp_data = 16'($urandom);
            else smp_data = 16'($urandom_range(0, 600) - 300);
            @(negedge clk);
        end
        smp_valid = 1'b0;
        idle(2);
        finish_run();
    end
endmodule